// File: doc/BRIEF.md
# Shadowed Overlay Window Register Bank

This block holds the per-window geometry and memory parameters of a display controller that composes several overlay windows. Software writes go into a shadow copy of each window: an enable bit, a top-left and an inclusive bottom-right screen coordinate, a buffer start and end address, a packed stride word and two stored-only alpha words. The scan-out logic reads a separate active copy. The active copy changes only at a frame boundary, so a frame never shows half of an update.

A commit is requested by writing 1 to a global update bit. The bit reads back as 1 while the request is pending. At the next frame-boundary pulse, every window whose protect bit is clear copies its shadow into its active set, and the request clears itself. A protected window keeps its active values and its shadow contents, so a later commit can still pick them up. Software therefore changes several registers of one window under protection and releases them together.

The stride word is decoded after the active copy, in one of two layouts chosen by a global mode bit. One layout suits panel outputs and the other suits television-style outputs.

Top module: `ovl_window_bank`

## Requirements
- R1: After reset, every shadow register, active output, protect bit, the pending flag and the mode bit are 0, and every address reads 0.
- R2: A register write changes only the shadow copy: it reads back at once, and the active outputs do not change before a commit.
- R3: Writing a word with bit 0 set to the update register sets the pending flag, which reads back in bit 0. Writing bit 0 as 0 has no effect. The flag stays set until a commit, and a new request in the same cycle as a commit leaves it set.
- R4: At a frame-boundary pulse while a request is pending, every unprotected window's active set takes the shadow values, and the pending flag reads 0 from the next cycle.
- R5: A window whose protect bit (bit w of the protect register for window w) is set during a commit keeps its active values. Its shadow is retained, and a later commit after the bit is cleared applies it.
- R6: A frame-boundary pulse with no pending request changes no active output.
- R7: With the mode bit at 0, the line skip output is stride bits 27:14 and the line width output is stride bits 13:0.
- R8: With the mode bit at 1, the line skip output is stride bits 29:15 and the line width output is stride bits 14:0. The mode bit is not shadowed and applies from the cycle after its write.
- R9: The two alpha words per window are stored and read back in full, but they change no output.
- R10: Address bits 5:3 select window 0 to 4, and the value 7 selects the global registers. Bits 2:0 select the field. The window fields are: 0 control (enable in bit 0), 1 top-left, 2 bottom-right, 3 and 4 alpha, 5 start address, 6 end address, 7 stride. A coordinate word carries X in bits 10:0 and Y in bits 26:16. The global fields are 0 protect, 1 update and 2 mode (bit 0). Unlisted bits read 0, and unmapped addresses read 0 and ignore writes.
- R11: The disable sequence (protect the window, clear its enable, unprotect it, request an update) turns that window off at the next frame pulse and leaves the other windows as they were.
- R12: When a shadow write and a committing frame pulse fall in the same cycle, the active copy takes the value held before the write, and the new value waits for the next commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register address (window index, field) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| frame_tick | input | 1 | One-cycle frame-boundary pulse |
| upd_pending | output | 1 | Commit request waiting for a frame pulse |
| act_en | output | 5 | Active enable, one bit per window |
| act_x0 | output | 55 | Active left X, 11 bits per window |
| act_y0 | output | 55 | Active top Y, 11 bits per window |
| act_x1 | output | 55 | Active inclusive right X per window |
| act_y1 | output | 55 | Active inclusive bottom Y per window |
| act_base | output | 160 | Active buffer start address, 32 bits per window |
| act_limit | output | 160 | Active buffer end address, 32 bits per window |
| act_skip | output | 75 | Decoded line skip in bytes, 15 bits per window |
| act_width | output | 75 | Decoded visible line width in bytes, 15 bits per window |

## Verification
On every cycle, the assertions check the commit rules per window. A protected window's active set holds through a commit. An unprotected window's active set equals the shadow from the cycle before. Nothing active moves without a pending commit. They also check the pending flag: it is set by a request, held until a frame pulse and cleared by it, and unmapped addresses read zero. Only the bench scenarios show the following: the field packing and masks of the address map, the two stride layouts, the ordered disable sequence, that alpha writes leave the outputs alone, and the ordering of a shadow write against a commit in the same cycle. In those scenarios every output is compared with a model of the register map.

// File: rtl/ovl_pkg.sv
package ovl_pkg;
  localparam int CW    = 11;
  localparam int AW    = 32;
  localparam int DW    = 32;
  localparam int SW    = 15;
  localparam int Y_LSB = 16;
  localparam int FLD_W = 3;

  typedef enum logic [FLD_W-1:0] {
    F_CTRL = 3'd0, F_TL = 3'd1, F_BR = 3'd2, F_ALPHA_A = 3'd3,
    F_ALPHA_B = 3'd4, F_BASE = 3'd5, F_LIMIT = 3'd6, F_STRIDE = 3'd7
  } wfield_e;

  localparam logic [FLD_W-1:0] G_PROT = 3'd0;
  localparam logic [FLD_W-1:0] G_UPD  = 3'd1;
  localparam logic [FLD_W-1:0] G_MODE = 3'd2;

  typedef struct packed {
    logic          en;
    logic [CW-1:0] x0;
    logic [CW-1:0] y0;
    logic [CW-1:0] x1;
    logic [CW-1:0] y1;
    logic [AW-1:0] base;
    logic [AW-1:0] limit;
    logic [DW-1:0] stride;
  } win_t;

  function automatic logic [DW-1:0] pack_xy(logic [CW-1:0] x, logic [CW-1:0] y);
    logic [DW-1:0] r;
    r = '0;
    r[CW-1:0] = x;
    r[Y_LSB +: CW] = y;
    return r;
  endfunction

  function automatic logic [SW-1:0] stride_skip(logic [DW-1:0] s, logic alt);
    return alt ? s[29:15] : {1'b0, s[27:14]};
  endfunction

  function automatic logic [SW-1:0] stride_len(logic [DW-1:0] s, logic alt);
    return alt ? s[14:0] : {1'b0, s[13:0]};
  endfunction
endpackage

// File: rtl/ovl_shadow_regs.sv
module ovl_shadow_regs import ovl_pkg::*; #(
  parameter int NWIN = 5,
  parameter int IDXW = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we,
  input  logic [IDXW+FLD_W-1:0] addr,
  input  logic [DW-1:0]         wdata,
  input  logic                  pending,
  output win_t                  shadow [NWIN],
  output logic [NWIN-1:0]       protect,
  output logic                  alt_mode,
  output logic                  upd_req,
  output logic [DW-1:0]         rdata
);
  localparam logic [IDXW-1:0] GLOB = '1;

  logic [IDXW-1:0]  idx;
  logic [FLD_W-1:0] fld;
  wfield_e          wf;
  logic             is_glob, is_win;
  logic [DW-1:0]    alpha_a [NWIN];
  logic [DW-1:0]    alpha_b [NWIN];

  assign idx     = addr[IDXW+FLD_W-1:FLD_W];
  assign fld     = addr[FLD_W-1:0];
  assign wf      = wfield_e'(fld);
  assign is_glob = (idx == GLOB);
  assign is_win  = (int'(idx) < NWIN);
  assign upd_req = we && is_glob && (fld == G_UPD) && wdata[0];

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    win_t          s;
    logic [DW-1:0] aa, ab;
    logic          hit;
    assign hit = we && is_win && (int'(idx) == w);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s  <= '0;
        aa <= '0;
        ab <= '0;
      end else if (hit) begin
        case (wf)
          F_CTRL:    s.en <= wdata[0];
          F_TL:      begin s.x0 <= wdata[CW-1:0]; s.y0 <= wdata[Y_LSB +: CW]; end
          F_BR:      begin s.x1 <= wdata[CW-1:0]; s.y1 <= wdata[Y_LSB +: CW]; end
          F_ALPHA_A: aa <= wdata;
          F_ALPHA_B: ab <= wdata;
          F_BASE:    s.base <= wdata;
          F_LIMIT:   s.limit <= wdata;
          F_STRIDE:  s.stride <= wdata;
          default:   ;
        endcase
      end
    end
    assign shadow[w]  = s;
    assign alpha_a[w] = aa;
    assign alpha_b[w] = ab;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      protect  <= '0;
      alt_mode <= 1'b0;
    end else if (we && is_glob) begin
      if (fld == G_PROT) protect  <= wdata[NWIN-1:0];
      if (fld == G_MODE) alt_mode <= wdata[0];
    end
  end

  win_t          rs;
  logic [DW-1:0] ra, rb;
  always_comb begin
    rs = '0;
    ra = '0;
    rb = '0;
    for (int w = 0; w < NWIN; w++) begin
      if (int'(idx) == w) begin
        rs = shadow[w];
        ra = alpha_a[w];
        rb = alpha_b[w];
      end
    end
    rdata = '0;
    if (is_glob) begin
      if (fld == G_PROT) rdata[NWIN-1:0] = protect;
      if (fld == G_UPD)  rdata[0] = pending;
      if (fld == G_MODE) rdata[0] = alt_mode;
    end else if (is_win) begin
      case (wf)
        F_CTRL:    rdata[0] = rs.en;
        F_TL:      rdata = pack_xy(rs.x0, rs.y0);
        F_BR:      rdata = pack_xy(rs.x1, rs.y1);
        F_ALPHA_A: rdata = ra;
        F_ALPHA_B: rdata = rb;
        F_BASE:    rdata = rs.base;
        F_LIMIT:   rdata = rs.limit;
        F_STRIDE:  rdata = rs.stride;
        default:   rdata = '0;
      endcase
    end
  end

  // R10: an address outside the window range and the global page reads zero
  assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_glob && !is_win) |-> (rdata == '0));
endmodule

// File: rtl/ovl_commit_ctl.sv
module ovl_commit_ctl #(
  parameter int NWIN = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            frame_tick,
  input  logic            upd_req,
  input  logic [NWIN-1:0] protect,
  output logic            pending,
  output logic [NWIN-1:0] load
);
  logic fire;
  assign fire = frame_tick && pending;
  assign load = {NWIN{fire}} & ~protect;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pending <= 1'b0;
    else        pending <= (pending && !frame_tick) || upd_req;
  end

  assert_req_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    upd_req |=> pending);
  assert_pending_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !frame_tick) |=> pending);
  assert_pending_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !upd_req) |=> !pending);
endmodule

// File: rtl/ovl_active_set.sv
module ovl_active_set import ovl_pkg::*; #(
  parameter int NWIN = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NWIN-1:0] load,
  input  win_t            shadow [NWIN],
  output win_t            active [NWIN]
);
  for (genvar w = 0; w < NWIN; w++) begin : g_act
    win_t r;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       r <= '0;
      else if (load[w]) r <= shadow[w];
    end
    assign active[w] = r;
  end
endmodule

// File: rtl/ovl_window_bank.sv
module ovl_window_bank import ovl_pkg::*; #(
  parameter  int NWIN = 5,
  localparam int IDXW = $clog2(NWIN + 1),
  localparam int RAW  = IDXW + FLD_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_we,
  input  logic [RAW-1:0]     reg_addr,
  input  logic [DW-1:0]      reg_wdata,
  output logic [DW-1:0]      reg_rdata,
  input  logic               frame_tick,
  output logic               upd_pending,
  output logic [NWIN-1:0]    act_en,
  output logic [NWIN*CW-1:0] act_x0,
  output logic [NWIN*CW-1:0] act_y0,
  output logic [NWIN*CW-1:0] act_x1,
  output logic [NWIN*CW-1:0] act_y1,
  output logic [NWIN*AW-1:0] act_base,
  output logic [NWIN*AW-1:0] act_limit,
  output logic [NWIN*SW-1:0] act_skip,
  output logic [NWIN*SW-1:0] act_width
);
  win_t            shadow [NWIN];
  win_t            active [NWIN];
  logic [NWIN-1:0] protect, load;
  logic            alt_mode, upd_req;

  ovl_shadow_regs #(.NWIN(NWIN), .IDXW(IDXW)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .pending(upd_pending), .shadow(shadow), .protect(protect),
    .alt_mode(alt_mode), .upd_req(upd_req), .rdata(reg_rdata));

  ovl_commit_ctl #(.NWIN(NWIN)) u_ctl (
    .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .upd_req(upd_req),
    .protect(protect), .pending(upd_pending), .load(load));

  ovl_active_set #(.NWIN(NWIN)) u_act (
    .clk(clk), .rst_n(rst_n), .load(load), .shadow(shadow), .active(active));

  for (genvar w = 0; w < NWIN; w++) begin : g_out
    assign act_en[w]           = active[w].en;
    assign act_x0[w*CW +: CW]  = active[w].x0;
    assign act_y0[w*CW +: CW]  = active[w].y0;
    assign act_x1[w*CW +: CW]  = active[w].x1;
    assign act_y1[w*CW +: CW]  = active[w].y1;
    assign act_base[w*AW +: AW]  = active[w].base;
    assign act_limit[w*AW +: AW] = active[w].limit;
    assign act_skip[w*SW +: SW]  = stride_skip(active[w].stride, alt_mode);
    assign act_width[w*SW +: SW] = stride_len(active[w].stride, alt_mode);

    assert_protect_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_tick && upd_pending && protect[w]) |=> $stable(active[w]));
    assert_commit_copy_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_tick && upd_pending && !protect[w]) |=> (active[w] == $past(shadow[w])));
    assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(frame_tick && upd_pending) |=> $stable(active[w]));
  end
endmodule

// File: tb/sim_ovl_window_bank.sv
module sim_ovl_window_bank;
  localparam int NW = 5, CW = 11, SW = 15, AB = 6;

  logic clk = 1'b0, rst_n = 1'b0, we = 1'b0, tick = 1'b0;
  logic [AB-1:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic pend_o;
  logic [NW-1:0] en_o;
  logic [NW*CW-1:0] x0_o, y0_o, x1_o, y1_o;
  logic [NW*32-1:0] base_o, limit_o;
  logic [NW*SW-1:0] skip_o, width_o;

  always #10 clk = ~clk;

  ovl_window_bank #(.NWIN(NW)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(we), .reg_addr(addr), .reg_wdata(wdata),
    .reg_rdata(rdata), .frame_tick(tick), .upd_pending(pend_o), .act_en(en_o),
    .act_x0(x0_o), .act_y0(y0_o), .act_x1(x1_o), .act_y1(y1_o),
    .act_base(base_o), .act_limit(limit_o), .act_skip(skip_o), .act_width(width_o));

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  logic [31:0] sh [NW][8];
  logic [31:0] ac [NW][8];
  logic [NW-1:0] m_prot = '0;
  logic m_pend = 1'b0, m_alt = 1'b0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [AB-1:0] wa(int w, int f);
    return AB'(w * 8 + f);
  endfunction
  function automatic logic [AB-1:0] ga(int f);
    return AB'(56 + f);
  endfunction

  function automatic logic [31:0] fmask(int f);
    if (f == 0) return 32'h1;
    if (f == 1 || f == 2) return 32'h07FF_07FF;
    return 32'hFFFF_FFFF;
  endfunction

  function automatic logic [31:0] exp_read(logic [AB-1:0] a);
    int wi = int'(a[5:3]);
    int f = int'(a[2:0]);
    if (wi == 7) begin
      if (f == 0) return 32'(m_prot);
      if (f == 1) return 32'(m_pend);
      if (f == 2) return 32'(m_alt);
      return 32'h0;
    end
    if (wi < NW) return sh[wi][f];
    return 32'h0;
  endfunction

  task automatic model_write(logic [AB-1:0] a, logic [31:0] d);
    int wi = int'(a[5:3]);
    int f = int'(a[2:0]);
    if (wi == 7) begin
      if (f == 0) m_prot = d[NW-1:0];
      else if (f == 1 && d[0]) m_pend = 1'b1;
      else if (f == 2) m_alt = d[0];
    end else if (wi < NW) sh[wi][f] = d & fmask(f);
  endtask

  task automatic step(bit w, logic [AB-1:0] a, logic [31:0] d, bit t);
    @(negedge clk);
    we = w; addr = a; wdata = d; tick = t;
    @(negedge clk);
    we = 1'b0; tick = 1'b0;
    if (t && m_pend) begin
      for (int i = 0; i < NW; i++)
        if (!m_prot[i]) for (int f = 0; f < 8; f++) ac[i][f] = sh[i][f];
      m_pend = 1'b0;
    end
    if (w) model_write(a, d);
  endtask

  task automatic wr(logic [AB-1:0] a, logic [31:0] d);
    step(1'b1, a, d, 1'b0);
  endtask
  task automatic frame();
    step(1'b0, '0, '0, 1'b1);
  endtask

  task automatic rd(logic [AB-1:0] a, string tag);
    addr = a;
    #1;
    chk(tag, rdata, exp_read(a));
  endtask

  task automatic compare_all(string tag);
    logic [31:0] s, es, ew;
    for (int w = 0; w < NW; w++) begin
      chk(tag, 32'(en_o[w]), ac[w][0] & 32'h1);
      chk(tag, 32'(x0_o[w*CW +: CW]), ac[w][1] & 32'h7FF);
      chk(tag, 32'(y0_o[w*CW +: CW]), (ac[w][1] >> 16) & 32'h7FF);
      chk(tag, 32'(x1_o[w*CW +: CW]), ac[w][2] & 32'h7FF);
      chk(tag, 32'(y1_o[w*CW +: CW]), (ac[w][2] >> 16) & 32'h7FF);
      chk(tag, base_o[w*32 +: 32], ac[w][5]);
      chk(tag, limit_o[w*32 +: 32], ac[w][6]);
      s = ac[w][7];
      es = m_alt ? (s >> 15) & 32'h7FFF : (s >> 14) & 32'h3FFF;
      ew = m_alt ? s & 32'h7FFF : s & 32'h3FFF;
      chk(tag, 32'(skip_o[w*SW +: SW]), es);
      chk(tag, 32'(width_o[w*SW +: SW]), ew);
    end
    chk(tag, 32'(pend_o), 32'(m_pend));
  endtask

  task automatic fill(int seed);
    int x, y, ww, hh, pitch;
    logic [31:0] base;
    for (int w = 0; w < NW; w++) begin
      x = w * 97 + seed;
      y = w * 53 + 2 * seed;
      ww = 40 + w * 8 + seed;
      hh = 30 + w * 5;
      pitch = ww * 4 + 64;
      base = 32'h4000_0000 + 32'(w << 20) + 32'(seed << 12);
      wr(wa(w, 0), 32'hA5A5_0001);
      wr(wa(w, 1), 32'hF800_F800 | 32'((y << 16) | x));
      wr(wa(w, 2), 32'(((y + hh - 1) << 16) | (x + ww - 1)));
      wr(wa(w, 3), 32'h1111_0000 + 32'(w * 16 + seed));
      wr(wa(w, 4), 32'h2222_0000 + 32'(w * 16 + seed));
      wr(wa(w, 5), base);
      wr(wa(w, 6), base + 32'(pitch * hh));
      wr(wa(w, 7), 32'(((pitch - ww * 4) << 14) | (ww * 4)));
    end
  endtask

  task automatic sweep_reads(string tag);
    for (int a = 0; a < 64; a++) rd(AB'(a), tag);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    for (int w = 0; w < NW; w++)
      for (int f = 0; f < 8; f++) begin sh[w][f] = '0; ac[w][f] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    compare_all("R1");
    sweep_reads("R1");

    fill(1);
    sweep_reads("R2");
    sweep_reads("R10");
    compare_all("R2");

    frame();
    compare_all("R6");

    wr(ga(1), 32'hFFFF_FFFE);
    rd(ga(1), "R3");
    chk("R3", 32'(pend_o), 32'h0);
    wr(ga(1), 32'h1);
    rd(ga(1), "R3");
    compare_all("R2");
    frame();
    compare_all("R4");
    compare_all("R7");
    rd(ga(1), "R4");
    frame();
    compare_all("R6");

    wr(ga(0), 32'h0000_000A);
    fill(2);
    wr(ga(1), 32'h1);
    frame();
    compare_all("R5");
    sweep_reads("R5");
    wr(ga(0), 32'h0);
    wr(ga(1), 32'h1);
    frame();
    compare_all("R5");

    wr(wa(4, 7), 32'h3FFF_FFFF);
    wr(wa(3, 7), 32'h2AAA_D555);
    wr(ga(1), 32'h1);
    frame();
    compare_all("R7");
    wr(ga(2), 32'h1);
    rd(ga(2), "R8");
    compare_all("R8");

    for (int w = 0; w < NW; w++) begin
      wr(wa(w, 3), 32'hDEAD_BEE0 ^ 32'(w));
      wr(wa(w, 4), 32'h0BAD_F00D ^ 32'(w << 8));
    end
    compare_all("R9");
    sweep_reads("R9");
    wr(ga(1), 32'h1);
    frame();
    compare_all("R9");

    wr(ga(0), 32'h4);
    wr(wa(2, 0), 32'h0);
    wr(ga(0), 32'h0);
    wr(ga(1), 32'h1);
    compare_all("R11");
    chk("R11", 32'(en_o[2]), 32'h1);
    frame();
    compare_all("R11");
    chk("R11", 32'(en_o[2]), 32'h0);
    chk("R11", 32'(en_o[1]), 32'h1);

    wr(ga(1), 32'h1);
    step(1'b1, wa(0, 5), 32'hDEAD_0000, 1'b1);
    compare_all("R12");
    rd(wa(0, 5), "R12");
    wr(ga(1), 32'h1);
    frame();
    compare_all("R12");

    wr(ga(1), 32'h1);
    step(1'b1, ga(1), 32'h1, 1'b1);
    rd(ga(1), "R3");
    frame();
    compare_all("R3");

    wr(wa(5, 5), 32'h1234_5678);
    wr(wa(6, 0), 32'h1);
    wr(ga(4), 32'hFFFF_FFFF);
    wr(ga(7), 32'hFFFF_FFFF);
    sweep_reads("R10");
    wr(ga(1), 32'h1);
    frame();
    compare_all("R10");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule